// File: doc/BRIEF.md
# Anti-Blooming Exposure Controller

This block sets the exposure time of a line-scan photodiode array. It drives the level of the anti-blooming drain gate. While that gate is high, charge in every photodiode is dumped to the drain. While it is low, the photodiodes collect charge. The clock sequencer gives the block a one-cycle strobe at the falling edge of the photo gate, which is the moment the previous charge packets have moved into the readout register. Each strobe starts a new line period. From the strobe onward, the block counts clock cycles and compares the count with a programmed line length and a programmed exposure length.

After a short guard delay that follows the strobe, the gate rises and the photodiodes are drained. The gate falls again so that the last exposure-length cycles before the next strobe are spent integrating. The integration window is therefore always placed at the end of the line, just before the next transfer. The charge collected in one line is read out as video during the following line.

Both programmed values are captured at the strobe, so software may rewrite them at any time without tearing a line. If the requested exposure leaves no room for a drain pulse of at least the minimum length, the drain is suppressed for the whole line and the photodiodes integrate for the full line.

Top module: `abx_exposure_ctrl`

## Requirements
- R1: A transfer strobe sampled high on a clock edge restarts the line count at 0. The gate output is low in the cycle that follows that edge.
- R2: When the drain is enabled for the line, the gate is high exactly when the number of edges n since the strobe edge satisfies GUARD_CYC <= n < line - expo. With the defaults GUARD_CYC = 1 and DRAIN_MIN = 150, and line = 400, expo = 100, the gate is high for n = 1 through 299 and low from n = 300.
- R3: An exposure of 0 keeps the gate high from n = GUARD_CYC up to the end of the programmed line (n = line - 1).
- R4: The drain is enabled for a line only when expo + GUARD_CYC + DRAIN_MIN < line. Otherwise the gate stays low for the whole line, which gives full-line integration. With the defaults, line = 400 and expo = 249 gives a low gate, and line = 151 with expo = 0 gives a low gate.
- R5: Any drain pulse that ends by itself, rather than being cut off by a strobe, lasts at least DRAIN_MIN + 1 cycles. With line = 152 and expo = 0 the pulse is exactly 151 cycles long.
- R6: A change of the line or exposure inputs between strobes has no effect on the current line. It takes effect from the next strobe.
- R7: A strobe that arrives before the programmed line end ends any drain pulse at once (the gate is low on the next cycle) and starts a new line.
- R8: After reset the gate is low, and it stays low until the first strobe, whatever the line and exposure inputs hold.
- R9: The line count stops at 2^CNT_W - 1. Once it has stopped, the gate is low. With CNT_W = 12, line = 4095 and expo = 0, the gate is high at n = 4094 and low at n = 4095 and later.
- R10: The line and exposure values present on the same edge as the strobe are the ones used for the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_i | input | 1 | One-cycle strobe at the photo-gate falling edge; starts a line |
| line_len_i | input | CNT_W | Line period in clock cycles, captured at the strobe |
| expo_len_i | input | CNT_W | Integration length in clock cycles at the end of the line, captured at the strobe |
| ab_gate_o | output | 1 | Anti-blooming gate level, high = drain |

## Verification
Two events can land on the same edge: the strobe that starts a new line, and a change of the programmed values, or the strobe and a drain pulse that is still high. The bench changes the line and exposure inputs on the very edge that carries the strobe, and expects the new values to govern the line that starts there. It also fires a strobe in the middle of a high drain pulse and expects the gate to drop on the next cycle and rise again one guard delay later. A strobe that arrives mid-pulse together with values that disable the drain must leave the gate low for the whole of the new line.

// File: rtl/abx_pkg.sv
package abx_pkg;
   // Output stage variant of the gate driver
   typedef enum logic {
      GATE_REG  = 1'b0,   // gate driven from a flop (glitch-free)
      GATE_COMB = 1'b1    // gate decoded directly from the count
   } gate_mode_e;
endpackage

// File: rtl/abx_line_timer.sv
module abx_line_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_d
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial assert (CNT_W >= 2) else $error("abx_line_timer: CNT_W too small");

   always_comb begin
      if (restart)
         cnt_d = '0;
      else if (cnt_q == CNT_MAX)
         cnt_d = cnt_q;
      else
         cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assert_restart_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt_q == '0);

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

   assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/abx_shadow.sv
module abx_shadow #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] line_i,
   input  logic [CNT_W-1:0] expo_i,
   output logic [CNT_W-1:0] line_q,
   output logic [CNT_W-1:0] expo_q,
   output logic [CNT_W-1:0] line_d,
   output logic [CNT_W-1:0] expo_d
);
   assign line_d = load ? line_i : line_q;
   assign expo_d = load ? expo_i : expo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
         expo_q <= '0;
      end else begin
         line_q <= line_d;
         expo_q <= expo_d;
      end
   end

   assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(line_q) && $stable(expo_q)));

   assert_capture_at_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (line_q == $past(line_i) && expo_q == $past(expo_i)));
endmodule

// File: rtl/abx_window.sv
module abx_window #(
   parameter int CNT_W     = 12,
   parameter int GUARD_CYC = 1,
   parameter int DRAIN_MIN = 150
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] line_i,
   input  logic [CNT_W-1:0] expo_i,
   output logic             drain_en_o,
   output logic             gate_o
);
   localparam int            W2      = CNT_W + 2;
   localparam logic [W2-1:0] GUARD_W = W2'(GUARD_CYC);
   localparam logic [W2-1:0] MIN_W   = W2'(DRAIN_MIN);

   logic [W2-1:0] c_w, l_w, e_w, need_w, rel_w;

   assign c_w    = W2'(cnt_i);
   assign l_w    = W2'(line_i);
   assign e_w    = W2'(expo_i);
   assign need_w = e_w + GUARD_W + MIN_W;
   assign rel_w  = l_w - e_w;

   assign drain_en_o = need_w < l_w;
   assign gate_o     = drain_en_o && (c_w >= GUARD_W) && (c_w < rel_w);
endmodule

// File: rtl/abx_exposure_ctrl.sv
module abx_exposure_ctrl #(
   parameter int                 CNT_W     = 12,
   parameter int                 GUARD_CYC = 1,
   parameter int                 DRAIN_MIN = 150,
   parameter abx_pkg::gate_mode_e GATE_MODE = abx_pkg::GATE_REG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_i,
   input  logic [CNT_W-1:0] line_len_i,
   input  logic [CNT_W-1:0] expo_len_i,
   output logic             ab_gate_o
);
   localparam logic [CNT_W-1:0] GUARD_C = CNT_W'(GUARD_CYC);
   localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(DRAIN_MIN);
   localparam logic [CNT_W-1:0] RUN_MAX = '1;
   localparam bit               USE_REG = (GATE_MODE == abx_pkg::GATE_REG);

   initial assert (GUARD_CYC >= 1) else $error("abx_exposure_ctrl: GUARD_CYC must be >= 1");
   initial assert (DRAIN_MIN >= 1) else $error("abx_exposure_ctrl: DRAIN_MIN must be >= 1");
   initial assert (GUARD_CYC + DRAIN_MIN < (1 << CNT_W))
      else $error("abx_exposure_ctrl: guard plus drain does not fit CNT_W");

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] line_q, expo_q, line_d, expo_d;
   logic [CNT_W-1:0] cnt_sel, line_sel, expo_sel;
   logic             win_gate, win_en;

   abx_line_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (xfer_i),
      .cnt_q   (cnt_q),
      .cnt_d   (cnt_d)
   );

   abx_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (xfer_i),
      .line_i (line_len_i),
      .expo_i (expo_len_i),
      .line_q (line_q),
      .expo_q (expo_q),
      .line_d (line_d),
      .expo_d (expo_d)
   );

   // A registered gate decodes next-state values so both variants agree cycle for cycle
   assign cnt_sel  = USE_REG ? cnt_d  : cnt_q;
   assign line_sel = USE_REG ? line_d : line_q;
   assign expo_sel = USE_REG ? expo_d : expo_q;

   abx_window #(
      .CNT_W     (CNT_W),
      .GUARD_CYC (GUARD_CYC),
      .DRAIN_MIN (DRAIN_MIN)
   ) u_window (
      .cnt_i      (cnt_sel),
      .line_i     (line_sel),
      .expo_i     (expo_sel),
      .drain_en_o (win_en),
      .gate_o     (win_gate)
   );

   generate
      if (USE_REG) begin : g_reg
         logic gate_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gate_q <= 1'b0;
            else        gate_q <= win_gate;
         end
         assign ab_gate_o = gate_q;
      end else begin : g_comb
         assign ab_gate_o = win_gate;
      end
   endgenerate

   // Length of the current high run of the gate, for the pulse-width check
   logic [CNT_W-1:0] hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hi_run <= '0;
      else if (!ab_gate_o)     hi_run <= '0;
      else if (hi_run != RUN_MAX) hi_run <= hi_run + 1'b1;
   end

   assert_low_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_i |=> !ab_gate_o);

   assert_rise_at_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ab_gate_o) |-> cnt_q == GUARD_C);

   assert_no_drain_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_q <= expo_q) |-> !ab_gate_o);

   assert_min_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ab_gate_o) && !$past(xfer_i)) |-> hi_run > MIN_C);

   assert_gate_en_consistent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (USE_REG && ab_gate_o) |-> $past(win_en));
endmodule

// File: tb/sim_abx_exposure_ctrl.sv
module sim_abx_exposure_ctrl;
   localparam int CNT_W = 12;
   localparam int G     = 1;
   localparam int D     = 150;
   localparam int NV    = 14;

   // line, expo, edges after strobe, expected gate, requirement
   localparam int VEC [NV][5] = '{
      '{400,   0,   0, 0, 1},   // R1 low right after strobe
      '{400,   0,   1, 1, 2},   // R2 rise after guard
      '{400,   0, 399, 1, 3},   // R3 zero exposure drains to line end
      '{400, 100, 299, 1, 2},   // R2 last drain cycle
      '{400, 100, 300, 0, 2},   // R2 integration begins
      '{400, 248, 151, 1, 4},   // R4 largest enabled exposure
      '{400, 248, 152, 0, 4},   // R4 release point
      '{400, 249,  50, 0, 4},   // R4 drain suppressed at boundary
      '{400, 500,  50, 0, 4},   // R4 exposure beyond line
      '{100,   0,  50, 0, 4},   // R4 line too short
      '{151,   0,   1, 0, 4},   // R4 line one short of minimum
      '{152,   0,   1, 1, 5},   // R5 shortest enabled line
      '{152,   0, 151, 1, 5},   // R5 pulse end
      '{152,   0, 152, 0, 5}    // R5 released
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             xfer = 1'b0;
   logic [CNT_W-1:0] line_len = '0;
   logic [CNT_W-1:0] expo_len = '0;
   logic             ab_gate;

   int checks = 0;
   int fails  = 0;
   int pos    = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   abx_exposure_ctrl #(
      .CNT_W     (CNT_W),
      .GUARD_CYC (G),
      .DRAIN_MIN (D)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_i     (xfer),
      .line_len_i (line_len),
      .expo_len_i (expo_len),
      .ab_gate_o  (ab_gate)
   );

   task automatic check(input logic got, input logic exp, input string req);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s gate=%0b expected=%0b (edge %0d)", req, got, exp, pos);
      end
   endtask

   // Strobe and new values on the same edge; returns at the negedge after it (n = 0)
   task automatic start_line(input int ln, input int ex);
      @(negedge clk);
      line_len = CNT_W'(ln);
      expo_len = CNT_W'(ex);
      xfer = 1'b1;
      @(negedge clk);
      xfer = 1'b0;
      pos = 0;
   endtask

   task automatic advance_to(input int n);
      repeat (n - pos) @(negedge clk);
      pos = n;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      check(ab_gate, 1'b0, "R8");
      rst_n = 1'b1;
      line_len = CNT_W'(400);
      expo_len = '0;
      repeat (20) @(negedge clk);
      check(ab_gate, 1'b0, "R8");

      for (int i = 0; i < NV; i++) begin
         start_line(VEC[i][0], VEC[i][1]);
         advance_to(VEC[i][2]);
         check(ab_gate, VEC[i][3] != 0, $sformatf("R%0d", VEC[i][4]));
      end

      // R5: measured pulse width on the shortest enabled line
      begin
         int highs = 0;
         start_line(152, 0);
         for (int k = 0; k < 160; k++) begin
            if (ab_gate) highs++;
            @(negedge clk);
         end
         checks++;
         if (highs != D + 1) begin
            fails++;
            $display("FAIL R5 pulse=%0d expected=%0d", highs, D + 1);
         end
      end

      // R6: mid-line rewrite ignored, applied on the next line
      start_line(400, 100);
      advance_to(100);
      expo_len = '0;
      advance_to(350);
      check(ab_gate, 1'b0, "R6");
      @(negedge clk);
      xfer = 1'b1;
      @(negedge clk);
      xfer = 1'b0;
      pos = 0;
      advance_to(350);
      check(ab_gate, 1'b1, "R6");

      // R7/R10: strobe in the middle of a drain pulse
      start_line(400, 0);
      advance_to(200);
      check(ab_gate, 1'b1, "R7");
      start_line(400, 0);
      check(ab_gate, 1'b0, "R7");
      advance_to(1);
      check(ab_gate, 1'b1, "R7");
      advance_to(200);
      start_line(400, 300);
      advance_to(1);
      check(ab_gate, 1'b0, "R10");
      advance_to(200);
      check(ab_gate, 1'b0, "R10");

      // R9: count stops at its maximum
      start_line(4095, 0);
      advance_to(4094);
      check(ab_gate, 1'b1, "R9");
      advance_to(4095);
      check(ab_gate, 1'b0, "R9");
      advance_to(4400);
      check(ab_gate, 1'b0, "R9");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule